// File: doc/BRIEF.md
# Per-core inter-processor interrupt unit

This block gives every core of a multi-core cluster its own small bank of interrupt registers behind one shared 32-bit register port. Every access carries the requesting core's ID, and that ID selects which bank is read or written. Each bank holds a 32-bit pending-status word, a 32-bit enable word, eight 32-bit mailbox words and one interrupt output. Status bits can only be changed through two write-only ports. One port ORs bits into status. The other port clears the bits that are written.

A send register lets any core post one pending bit into the status of any other core. The write carries a target core ID and a 5-bit vector. The vector is turned into a one-hot set on the target's status. The interrupt output is held in a flop, and two different conditions move it. A set raises it when the new status has at least one enabled bit. A clear lowers it only when status becomes zero while enable is nonzero. A requester ID or a send target that is not a real core gets a decode-error response, and the access has no effect.

Every access completes in one cycle. Read data and the error flag appear on the cycle after the request.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every status, enable and mailbox word reads as zero and every bit of irq_o is low.
- R2: A write of value V to offset 0x08 ORs V into the requester's status. Status reads back at offset 0x00.
- R3: After any set (local or sent), irq_o of that core is high on the next cycle if the new status ANDed with enable is nonzero. This holds even when the set value is zero.
- R4: A write of V to offset 0x0C clears the bits of V in status. irq_o goes low only if the new status is zero and enable is nonzero. Otherwise irq_o keeps its value.
- R5: Writes to offset 0x00 leave status unchanged. Reads of offsets 0x08, 0x0C and 0x40 return zero.
- R6: The enable word is written and read at offset 0x04. A write to enable on its own never changes irq_o.
- R7: Offsets 0x20 to 0x3C hold eight mailbox words, and word index = (offset − 0x20) >> 2. Each word reads back the last value written to it.
- R8: Only the 8 address bits are decoded. A write to any other offset, including unaligned offsets, changes nothing, and a read of such an offset returns zero.
- R9: A write to offset 0x40 takes the target core from data bits 25:16 and the vector from bits 4:0. It acts as a set of (1 << vector) on the target core.
- R10: A requester ID ≥ N_CORES, or a send whose target ≥ N_CORES, raises err_o on the next cycle. Such an access changes no state, and its rdata_o is zero.
- R11: Each core's bank is independent. An access by one requester reads and writes only that requester's bank, except for the target of a send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| core_id_i | input | ID_W | ID of the requesting core; selects the bank |
| addr_i | input | 8 | Register offset within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| err_o | output | 1 | Decode error, valid the cycle after the request |
| irq_o | output | N_CORES | Per-core interrupt outputs |

## Verification
The hardest state to reach is the asymmetric hold of irq_o. One way is an interrupt that stays high after enable has been cleared, because status was cleared while enable was zero. The other is an interrupt raised by a set of zero, which happens only after enable is written over pending status. Directed sequences walk one core through both orders. A long randomized mix of reads, sets, clears, enable writes, sends and bad IDs then reaches the same conditions across all cores. In that mix the set and clear masks are often zero or narrow, so status returns to zero often.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] OFF_SEND = 8'h40;
  localparam int MBX_WORDS = 8;
  localparam int MBX_IW    = $clog2(MBX_WORDS);
  localparam int TGT_LSB   = 16;
  localparam int TGT_W     = 10;
  localparam int VEC_W     = 5;

  typedef struct packed {
    logic              set;
    logic              clr;
    logic              en_we;
    logic              mbx_we;
    logic [MBX_IW-1:0] mbx_idx;
    logic [31:0]       data;
  } core_op_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ID_W    = 10
) (
  input  logic            req_i,
  input  logic            we_i,
  input  logic [ID_W-1:0] core_id_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output core_op_t        op_o [N_CORES],
  output logic            err_o
);
  logic [TGT_W-1:0] tgt;
  logic [VEC_W-1:0] vec;
  logic             is_send, is_mbx, req_bad, tgt_bad;

  assign tgt     = wdata_i[TGT_LSB +: TGT_W];
  assign vec     = wdata_i[VEC_W-1:0];
  assign is_send = (addr_i == OFF_SEND);
  assign is_mbx  = (addr_i[7:5] == 3'b001) && (addr_i[1:0] == 2'b00);
  assign req_bad = (core_id_i >= ID_W'(N_CORES));
  assign tgt_bad = (tgt >= TGT_W'(N_CORES));
  assign err_o   = req_i && (req_bad || (we_i && is_send && tgt_bad));

  always_comb begin
    for (int k = 0; k < N_CORES; k++) begin
      op_o[k]         = '0;
      op_o[k].data    = wdata_i;
      op_o[k].mbx_idx = addr_i[MBX_IW+1:2];
      if (req_i && we_i && !err_o) begin
        if (is_send) begin
          if (tgt == TGT_W'(k)) begin
            op_o[k].set  = 1'b1;
            op_o[k].data = 32'h1 << vec;
          end
        end else if (core_id_i == ID_W'(k)) begin
          op_o[k].set    = (addr_i == OFF_SET);
          op_o[k].clr    = (addr_i == OFF_CLR);
          op_o[k].en_we  = (addr_i == OFF_EN);
          op_o[k].mbx_we = is_mbx;
        end
      end
    end
  end
endmodule

// File: rtl/ipi_core.sv
module ipi_core
  import ipi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  core_op_t    op_i,
  input  logic [7:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);
  logic [31:0] status_q, en_q, status_set, status_clr;
  logic [31:0] mbx_q [MBX_WORDS];
  logic        irq_q;

  assign status_set = status_q | op_i.data;
  assign status_clr = status_q & ~op_i.data;
  assign irq_o      = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
      for (int i = 0; i < MBX_WORDS; i++) mbx_q[i] <= '0;
    end else begin
      if (op_i.set) begin
        status_q <= status_set;
        if ((status_set & en_q) != 32'h0) irq_q <= 1'b1;
      end else if (op_i.clr) begin
        status_q <= status_clr;
        if (status_clr == 32'h0 && en_q != 32'h0) irq_q <= 1'b0;
      end
      if (op_i.en_we) en_q <= op_i.data;
      if (op_i.mbx_we) mbx_q[op_i.mbx_idx] <= op_i.data;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == OFF_STAT) rd_data_o = status_q;
    else if (rd_addr_i == OFF_EN) rd_data_o = en_q;
    else if (rd_addr_i[7:5] == 3'b001 && rd_addr_i[1:0] == 2'b00)
      rd_data_o = mbx_q[rd_addr_i[MBX_IW+1:2]];
  end

  p_irq_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.set && ((status_q | op_i.data) & en_q) != 32'h0) |=> irq_o);
  p_irq_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.clr && (status_q & ~op_i.data) == 32'h0 && en_q != 32'h0) |=> !irq_o);
  p_irq_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.clr && (status_q & ~op_i.data) != 32'h0) |=> $stable(irq_o));
  p_status_only_ports_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i.set && !op_i.clr) |=> $stable(status_q));
  p_irq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_i.set && !op_i.clr) |=> $stable(irq_o));
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ID_W    = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ID_W-1:0]    core_id_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               err_o,
  output logic [N_CORES-1:0] irq_o
);
  core_op_t    ops [N_CORES];
  logic [31:0] core_rd [N_CORES];
  logic [31:0] rd_sel, rdata_q;
  logic        dec_err, err_q;

  ipi_decode #(.N_CORES(N_CORES), .ID_W(ID_W)) u_dec (
    .req_i(req_i), .we_i(we_i), .core_id_i(core_id_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .op_o(ops), .err_o(dec_err)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    ipi_core u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .op_i(ops[k]), .rd_addr_i(addr_i),
      .rd_data_o(core_rd[k]), .irq_o(irq_o[k])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < N_CORES; k++)
      if (core_id_i == ID_W'(k)) rd_sel = core_rd[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (req_i && !we_i && !dec_err) ? rd_sel : 32'h0;
      err_q   <= dec_err;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  p_bad_id_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && core_id_i >= ID_W'(N_CORES)) |=> (err_o && rdata_o == 32'h0));
endmodule

// File: tb/ipi_unit_test.sv
`timescale 1ns/1ps
module ipi_unit_test;
  localparam int NC = 4;
  logic        clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [9:0]  cid = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        err;
  logic [NC-1:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_st [NC], m_en [NC];
  logic [31:0] m_mb [NC][8];
  logic [NC-1:0] m_irq;

  always #2.5 clk = ~clk;

  ipi_unit #(.N_CORES(NC), .ID_W(10)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .core_id_i(cid),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int id, logic [7:0] a);
    if (a == 8'h00) return m_st[id];
    if (a == 8'h04) return m_en[id];
    if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0) return m_mb[id][(a - 8'h20) >> 2];
    return 0;
  endfunction

  task automatic m_set(int id, logic [31:0] v);
    m_st[id] = m_st[id] | v;
    if ((m_st[id] & m_en[id]) != 0) m_irq[id] = 1;
  endtask

  task automatic m_write(int id, logic [7:0] a, logic [31:0] d);
    case (a)
      8'h04: m_en[id] = d;
      8'h08: m_set(id, d);
      8'h0C: begin
        m_st[id] = m_st[id] & ~d;
        if (m_st[id] == 0 && m_en[id] != 0) m_irq[id] = 0;
      end
      8'h40: m_set(int'(d[25:16]), 32'h1 << d[4:0]);
      default: if (a >= 8'h20 && a <= 8'h3C && a[1:0] == 0) m_mb[id][(a - 8'h20) >> 2] = d;
    endcase
  endtask

  task automatic acc(input bit w, input int id, input logic [7:0] a, input logic [31:0] d, input string tag);
    bit ee;
    logic [31:0] er;
    ee = (id >= NC) || (w && a == 8'h40 && int'(d[25:16]) >= NC);
    er = 0;
    if (!ee && !w) er = m_read(id, a);
    if (!ee && w) m_write(id, a, d);
    @(negedge clk);
    req = 1; we = w; cid = 10'(id); addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    chk(err == ee, {tag, " err"}, 32'(err), 32'(ee));
    if (!w || ee) chk(rdata == er, {tag, " rdata"}, rdata, er);
    chk(irq == m_irq, {tag, " irq"}, 32'(irq), 32'(m_irq));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      m_st[i] = 0; m_en[i] = 0;
      for (int j = 0; j < 8; j++) m_mb[i][j] = 0;
    end
    m_irq = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    for (int i = 0; i < NC; i++) begin
      acc(0, i, 8'h00, 0, "R1 status");
      acc(0, i, 8'h04, 0, "R1 enable");
      acc(0, i, 8'h3C, 0, "R1 mailbox");
    end
    // R2 set, no enable -> no irq
    acc(1, 0, 8'h08, 32'h5, "R2 set");
    acc(0, 0, 8'h00, 0, "R2 status");
    // R6 enable write alone leaves irq low
    acc(1, 0, 8'h04, 32'h4, "R6 enable");
    acc(0, 0, 8'h04, 0, "R6 read enable");
    // R3 set of zero raises irq
    acc(1, 0, 8'h08, 32'h0, "R3 zero set");
    // R4 clear keeps irq while status nonzero, drops at zero
    acc(1, 0, 8'h0C, 32'h4, "R4 partial clear");
    acc(1, 0, 8'h0C, 32'h1, "R4 full clear");
    // R4 clear with enable zero keeps irq
    acc(1, 0, 8'h08, 32'h4, "R3 set");
    acc(1, 0, 8'h04, 32'h0, "R6 disable");
    acc(1, 0, 8'h0C, 32'hFFFF_FFFF, "R4 clear en zero");
    acc(1, 0, 8'h04, 32'h1, "R6 re-enable");
    acc(1, 0, 8'h0C, 32'h0, "R4 zero clear");
    // R5
    acc(1, 1, 8'h08, 32'hA0, "R5 set");
    acc(1, 1, 8'h00, 32'hFFFF_FFFF, "R5 status write");
    acc(0, 1, 8'h00, 0, "R5 status kept");
    acc(0, 1, 8'h08, 0, "R5 read set");
    acc(0, 1, 8'h0C, 0, "R5 read clr");
    acc(0, 1, 8'h40, 0, "R5 read send");
    // R7 / R11 mailbox
    for (int j = 0; j < 8; j++) acc(1, 2, 8'(8'h20 + 4 * j), 32'hC0DE_0000 + 32'(j), "R7 mbx wr");
    for (int j = 0; j < 8; j++) acc(0, 2, 8'(8'h20 + 4 * j), 0, "R7 mbx rd");
    acc(0, 1, 8'h24, 0, "R11 other bank");
    // R8 undecoded
    acc(1, 2, 8'h44, 32'h1, "R8 wr 44");
    acc(1, 2, 8'h21, 32'h1, "R8 wr unaligned");
    acc(1, 2, 8'h10, 32'h1, "R8 wr 10");
    acc(0, 2, 8'h20, 0, "R8 mbx kept");
    acc(0, 2, 8'h44, 0, "R8 rd 44");
    acc(0, 2, 8'h00, 0, "R8 status kept");
    // R9 send
    acc(1, 3, 8'h04, 32'h8000_0000, "R9 target enable");
    acc(1, 1, 8'h40, 32'h0003_001F, "R9 send v31");
    acc(0, 3, 8'h00, 0, "R9 target status");
    acc(1, 3, 8'h40, 32'h0003_0000, "R9 self send v0");
    acc(0, 3, 8'h00, 0, "R9 status v0");
    // R10 errors
    acc(1, 4, 8'h08, 32'hFF, "R10 bad id write");
    acc(0, 7, 8'h00, 0, "R10 bad id read");
    acc(1, 0, 8'h40, 32'h0005_0002, "R10 bad target");
    acc(0, 0, 8'h00, 0, "R10 no effect");
    // randomized mix against model
    for (int n = 0; n < 600; n++) begin
      int id, sel;
      logic [7:0] a;
      logic [31:0] d, msk;
      id  = ($urandom % 9 == 0) ? NC + int'($urandom % 3) : int'($urandom % NC);
      sel = int'($urandom % 8);
      a = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h04 : (sel == 2) ? 8'h08 :
          (sel == 3) ? 8'h0C : (sel == 4) ? 8'h40 : (sel == 5) ? 8'h44 :
          8'(8'h20 + 4 * ($urandom % 8));
      case ($urandom % 3)
        0: msk = 32'hFFFF_FFFF;
        1: msk = 32'h0000_000F;
        default: msk = 32'h0;
      endcase
      d = $urandom & msk;
      if (a == 8'h40) d = {6'd0, 10'($urandom % 6), 11'd0, 5'($urandom % 4)};
      acc(bit'($urandom % 2), id, a, d, "R11 mix");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule